// File: doc/BRIEF.md
# Multi-Mode Host Bus Front End

This block is the microcontroller-facing front end of a display controller. A host moves bytes into the controller over one of three bus styles that share the same pins: a parallel bus with a direction line and an enable strobe (6800 style), a parallel bus with separate active-low read and write strobes (8080 style), or a write-only clocked serial bus carried on the two top data lines. A static two-bit input picks the style. Each byte is tagged as either a command or display data by the level of a data/command pin.

All host pins are brought into the internal clock domain through a synchronizer. Each completed write comes out as a single-cycle pulse together with the byte and its command/data flag. A read raises a single-cycle request tagged the same way, captures the byte the core returns, and drives it onto the parallel bus until the host drops the read strobe or the chip select. A separate active-low host reset pin is filtered so that only a low pulse lasting a minimum time, counted in internal clock cycles, raises an initialization pulse.

Top module: `hostbus_if`

## Requirements
- R1: A transfer is accepted only while `cs1_n` is 0 and `cs2` is 1; with either one inactive, no write pulse, read request or bus drive occurs.
- R2: `wr_is_data` and `rd_is_data` equal the `dc_sel` level sampled with the transfer: 1 means display data, 0 means command.
- R3: In mode 00 (6800 style), a falling edge of `en_rdn` while `rw_wrn` is 0 completes a write; the pulse appears on the third rising clock edge after the strobe edge.
- R4: In mode 00, `rw_wrn` at 1 with `en_rdn` at 1 starts a read: exactly one `rd_req` pulse on the third rising edge, and from the fourth edge `bus_out` carries the byte given on `rd_byte` during that pulse, with `bus_oe` at 1.
- R5: In mode 01 (8080 style), a rising edge of `rw_wrn` (write strobe, active low) completes a write with the same three-edge latency.
- R6: In mode 01, `en_rdn` (read strobe) at 0 starts a read with the same timing as R4.
- R7: In mode 10 (serial), `bus_in[7]` is data and `bus_in[6]` is the clock; bits enter MSB first on rising clock edges, `dc_sel` is taken with the eighth bit, and the byte pulse appears on the third rising edge after the eighth clock edge.
- R8: In serial mode, deselecting the chip clears the bit count, so the next byte starts at its MSB.
- R9: Mode 11 disables every transfer: no write pulse, no read request, no bus drive.
- R10: `bus_oe` is 1 only during a selected parallel read and falls by the second rising edge after the read strobe or the chip select is released.
- R11: `init_req` pulses exactly once when `rst_pin_n` stays low for at least `CLK_MHZ*RST_MIN_US` cycles; a shorter low pulse gives none.
- R12: Each completed write gives exactly one one-cycle `wr_valid` pulse, with `bus_in[7]` as the MSB of `wr_byte` and `bus_in[0]` as the LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Bus style: 00 6800, 01 8080, 10 serial, 11 off |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| dc_sel | input | 1 | 1 = display data, 0 = command |
| rw_wrn | input | 1 | 6800 direction (1 read) / 8080 write strobe, active low |
| en_rdn | input | 1 | 6800 enable / 8080 read strobe, active low |
| bus_in | input | 8 | Host data bus input; bit 7 serial data, bit 6 serial clock |
| bus_out | output | 8 | Read data toward the host |
| bus_oe | output | 1 | Output enable for the host data bus |
| rst_pin_n | input | 1 | Host reset pin, active low |
| init_req | output | 1 | One-cycle initialization pulse |
| wr_valid | output | 1 | One-cycle write pulse |
| wr_byte | output | 8 | Written byte |
| wr_is_data | output | 1 | Write tag: 1 data, 0 command |
| rd_req | output | 1 | One-cycle read request |
| rd_is_data | output | 1 | Read tag: 1 data, 0 command |
| rd_byte | input | 8 | Byte returned by the core while `rd_req` is high |

## Verification
A host pin change goes through two synchronizer flops and one output register. A completed write or a read request therefore shows up on the third rising edge after the bench moves the strobe, the driven read byte on the fourth, and the release of the bus on the second. The bench changes pins on falling edges, counts exactly that many rising edges, and samples on the next falling edge. It checks the following falling edge too, to see that each pulse lasts one cycle. Pulse counters that run on every rising edge show that no extra or hidden transfer took place.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        BUS_M68 = 2'b00,
        BUS_I80 = 2'b01,
        BUS_SER = 2'b10,
        BUS_OFF = 2'b11
    } bus_mode_e;

    typedef struct packed {
        logic              cs1_n;
        logic              cs2;
        logic              dc;
        logic              rw_wrn;
        logic              en_rdn;
        logic [DATA_W-1:0] bus;
    } host_pins_t;

    typedef struct packed {
        logic              valid;
        logic              is_data;
        logic [DATA_W-1:0] dat;
    } wr_xfer_t;

    localparam host_pins_t PIN_IDLE = '{cs1_n: 1'b1, cs2: 1'b0, dc: 1'b0,
                                        rw_wrn: 1'b0, en_rdn: 1'b0, bus: '0};

    function automatic logic is_parallel(bus_mode_e m);
        return (m == BUS_M68) || (m == BUS_I80);
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= st[g-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/hb_par_engine.sv
module hb_par_engine
    import hostbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_mode_e         mode,
    input  logic              sel_cur,
    input  logic              sel_prv,
    input  logic              dc,
    input  logic              rw_cur,
    input  logic              rw_prv,
    input  logic              en_cur,
    input  logic              en_prv,
    input  logic [DATA_W-1:0] bus,
    input  logic [DATA_W-1:0] rd_byte,
    output wr_xfer_t          wr,
    output logic              rd_req,
    output logic              rd_is_data,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    logic m68, i80, sel_ok, wr_edge, rd_act, rd_act_q, oe_q;
    logic [DATA_W-1:0] rd_hold;

    assign m68    = (mode == BUS_M68);
    assign i80    = (mode == BUS_I80);
    assign sel_ok = sel_cur && sel_prv;

    always_comb begin
        wr_edge = 1'b0;
        rd_act  = 1'b0;
        if (m68) begin
            wr_edge = sel_ok && en_prv && !en_cur && !rw_cur && !rw_prv;
            rd_act  = sel_cur && rw_cur && en_cur;
        end else if (i80) begin
            wr_edge = sel_ok && !rw_prv && rw_cur;
            rd_act  = sel_cur && !en_cur && rw_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr         <= '0;
            rd_act_q   <= 1'b0;
            rd_req     <= 1'b0;
            rd_is_data <= 1'b0;
            rd_hold    <= '0;
            oe_q       <= 1'b0;
        end else begin
            wr.valid <= wr_edge;
            if (wr_edge) begin
                wr.dat     <= bus;
                wr.is_data <= dc;
            end
            rd_act_q <= rd_act;
            rd_req   <= rd_act && !rd_act_q;
            if (rd_act && !rd_act_q) rd_is_data <= dc;
            if (rd_req) rd_hold <= rd_byte;
            oe_q <= rd_act && (oe_q || rd_req);
        end
    end

    assign bus_oe  = oe_q && rd_act;
    assign bus_out = bus_oe ? rd_hold : '0;

    AST_PAR_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr.valid |=> !wr.valid); // R12
    AST_RD_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R4
    AST_OE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(rd_req)); // R4
    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> sel_cur); // R1
endmodule

// File: rtl/hb_ser_engine.sv
module hb_ser_engine
    import hostbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e mode,
    input  logic      sel_cur,
    input  logic      sel_prv,
    input  logic      sda,
    input  logic      sck_cur,
    input  logic      sck_prv,
    input  logic      dc,
    output wr_xfer_t  wr
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-2:0] shreg;
    logic              en, sck_rise;

    assign en       = (mode == BUS_SER);
    assign sck_rise = en && sel_cur && sel_prv && sck_cur && !sck_prv;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
            wr    <= '0;
        end else if (!en || !sel_cur) begin
            cnt      <= '0;
            wr.valid <= 1'b0;
        end else begin
            wr.valid <= 1'b0;
            if (sck_rise) begin
                shreg <= {shreg[DATA_W-3:0], sda};
                if (cnt == CNT_W'(DATA_W-1)) begin
                    cnt        <= '0;
                    wr.valid   <= 1'b1;
                    wr.dat     <= {shreg, sda};
                    wr.is_data <= dc;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_SER_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !sel_cur |=> (cnt == '0)); // R8
    AST_SER_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr.valid |=> !wr.valid); // R12
    AST_SER_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (rst)
        wr.valid |-> $past(en)); // R7
endmodule

// File: rtl/hb_rst_filter.sv
module hb_rst_filter #(
    parameter int MIN_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_s,
    output logic init_req
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || pin_n_s) begin
            cnt      <= '0;
            init_req <= 1'b0;
        end else begin
            init_req <= (cnt == CNT_W'(MIN_CYC - 1));
            if (cnt != CNT_W'(MIN_CYC)) cnt <= cnt + 1'b1;
        end
    end

    AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        init_req |=> !init_req); // R11
    AST_INIT_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        init_req |-> $past(!pin_n_s)); // R11
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hostbus_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int RST_MIN_US  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              dc_sel,
    input  logic              rw_wrn,
    input  logic              en_rdn,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              rst_pin_n,
    output logic              init_req,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_is_data,
    output logic              rd_req,
    output logic              rd_is_data,
    input  logic [DATA_W-1:0] rd_byte
);
    localparam int RST_MIN_CYC = CLK_MHZ * RST_MIN_US;
    localparam int PIN_W       = $bits(host_pins_t);
    localparam int SDA_BIT     = DATA_W - 1;
    localparam int SCK_BIT     = DATA_W - 2;

    bus_mode_e  mode;
    host_pins_t raw, cur;
    logic       sel_cur, sel_prv, rw_prv, en_prv, sck_prv, rst_pin_s;
    wr_xfer_t   par_wr, ser_wr;

    assign mode = bus_mode_e'(mode_sel);
    assign raw  = '{cs1_n: cs1_n, cs2: cs2, dc: dc_sel, rw_wrn: rw_wrn,
                    en_rdn: en_rdn, bus: bus_in};

    hb_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_pin_sync (
        .clk(clk), .rst(rst), .d(raw), .q(cur)
    );

    hb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk(clk), .rst(rst), .d(rst_pin_n), .q(rst_pin_s)
    );

    assign sel_cur = !cur.cs1_n && cur.cs2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prv <= 1'b0;
            rw_prv  <= PIN_IDLE.rw_wrn;
            en_prv  <= PIN_IDLE.en_rdn;
            sck_prv <= 1'b0;
        end else begin
            sel_prv <= sel_cur;
            rw_prv  <= cur.rw_wrn;
            en_prv  <= cur.en_rdn;
            sck_prv <= cur.bus[SCK_BIT];
        end
    end

    hb_par_engine u_par (
        .clk(clk), .rst(rst), .mode(mode),
        .sel_cur(sel_cur), .sel_prv(sel_prv), .dc(cur.dc),
        .rw_cur(cur.rw_wrn), .rw_prv(rw_prv),
        .en_cur(cur.en_rdn), .en_prv(en_prv),
        .bus(cur.bus), .rd_byte(rd_byte), .wr(par_wr),
        .rd_req(rd_req), .rd_is_data(rd_is_data),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    hb_ser_engine u_ser (
        .clk(clk), .rst(rst), .mode(mode),
        .sel_cur(sel_cur), .sel_prv(sel_prv),
        .sda(cur.bus[SDA_BIT]), .sck_cur(cur.bus[SCK_BIT]), .sck_prv(sck_prv),
        .dc(cur.dc), .wr(ser_wr)
    );

    hb_rst_filter #(.MIN_CYC(RST_MIN_CYC)) u_rst_flt (
        .clk(clk), .rst(rst), .pin_n_s(rst_pin_s), .init_req(init_req)
    );

    assign wr_valid   = par_wr.valid || ser_wr.valid;
    assign wr_byte    = par_wr.valid ? par_wr.dat     : ser_wr.dat;
    assign wr_is_data = par_wr.valid ? par_wr.is_data : ser_wr.is_data;

    AST_ONE_WR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({par_wr.valid, ser_wr.valid})); // R9
    AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_OFF && $past(mode == BUS_OFF)) |-> !wr_valid); // R9
    AST_OE_PARALLEL_ONLY: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> is_parallel(mode)); // R10
endmodule

// File: tb/sim_hostbus_if.sv
`timescale 1ns/1ps
module sim_hostbus_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       cs1_n = 1'b1, cs2 = 1'b0, dc_sel = 1'b0;
    logic       rw_wrn = 1'b0, en_rdn = 1'b0, rst_pin_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out, wr_byte, rd_byte;
    logic       bus_oe, init_req, wr_valid, wr_is_data, rd_req, rd_is_data;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, init_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign rd_byte = rd_is_data ? 8'hA5 : 8'h5A;

    hostbus_if u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs1_n(cs1_n), .cs2(cs2),
        .dc_sel(dc_sel), .rw_wrn(rw_wrn), .en_rdn(en_rdn), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rst_pin_n(rst_pin_n),
        .init_req(init_req), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .wr_is_data(wr_is_data), .rd_req(rd_req), .rd_is_data(rd_is_data),
        .rd_byte(rd_byte)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_valid) wr_cnt++;
            if (rd_req)   rd_cnt++;
            if (init_req) init_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic deselect();
        cs1_n = 1'b1; cs2 = 1'b0;
        tick(4);
    endtask

    // expect a write pulse on the third rising edge, then gone on the next
    task automatic expect_wr(input logic [7:0] d, input logic dcv, input string req);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wr_valid == 1'b1, req, wr_valid, 1);
        chk(wr_byte == d, req, wr_byte, d);
        chk(wr_is_data == dcv, {req, " R2"}, wr_is_data, dcv);
        @(negedge clk);
        chk(wr_valid == 1'b0, {req, " R12"}, wr_valid, 0);
    endtask

    task automatic t_reset();
        tick(2);
        chk(wr_valid == 0 && rd_req == 0, "R12 reset", {wr_valid, rd_req}, 0);
        chk(bus_oe == 0, "R10 reset", bus_oe, 0);
        chk(init_req == 0, "R11 reset", init_req, 0);
    endtask

    task automatic t_m68_write(input logic [7:0] d, input logic dcv, input bit sel);
        int start;
        mode_sel = 2'b00; rw_wrn = 1'b0; en_rdn = 1'b0; tick(4);
        cs1_n = !sel; cs2 = 1'b1; dc_sel = dcv; bus_in = d; tick(4);
        en_rdn = 1'b1; tick(4);
        start = wr_cnt;
        en_rdn = 1'b0;
        if (sel) expect_wr(d, dcv, "R3");
        tick(4);
        chk(wr_cnt - start == (sel ? 1 : 0), sel ? "R12 count" : "R1 cs1_n high",
            wr_cnt - start, sel ? 1 : 0);
        deselect();
    endtask

    task automatic t_i80_write(input logic [7:0] d, input logic dcv, input bit sel);
        int start;
        mode_sel = 2'b01; rw_wrn = 1'b1; en_rdn = 1'b1; tick(4);
        cs1_n = 1'b0; cs2 = sel; dc_sel = dcv; bus_in = d; tick(4);
        rw_wrn = 1'b0; tick(3);
        start = wr_cnt;
        rw_wrn = 1'b1;
        if (sel) expect_wr(d, dcv, "R5");
        tick(4);
        chk(wr_cnt - start == (sel ? 1 : 0), sel ? "R5 count" : "R1 cs2 low",
            wr_cnt - start, sel ? 1 : 0);
        deselect();
    endtask

    // read sequence common to both parallel styles
    task automatic rd_seq(input bit m68, input logic dcv, input bit drop_cs, input string req);
        int start;
        logic [7:0] exp;
        exp = dcv ? 8'hA5 : 8'h5A;
        cs1_n = 1'b0; cs2 = 1'b1; dc_sel = dcv; tick(4);
        start = rd_cnt;
        if (m68) en_rdn = 1'b1; else en_rdn = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_req == 1'b1, req, rd_req, 1);
        chk(rd_is_data == dcv, {req, " R2"}, rd_is_data, dcv);
        @(negedge clk);
        chk(bus_oe == 1'b1, {req, " R10 oe"}, bus_oe, 1);
        chk(bus_out == exp, {req, " data"}, bus_out, exp);
        tick(3);
        chk(bus_oe == 1'b1 && bus_out == exp, {req, " hold"}, bus_out, exp);
        if (drop_cs) cs1_n = 1'b1;
        else if (m68) en_rdn = 1'b0;
        else en_rdn = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(bus_oe == 1'b0, "R10 release", bus_oe, 0);
        tick(3);
        chk(rd_cnt - start == 1, {req, " one request"}, rd_cnt - start, 1);
        if (m68) en_rdn = 1'b0; else en_rdn = 1'b1;
        deselect();
    endtask

    task automatic t_m68_read(input logic dcv, input bit drop_cs);
        mode_sel = 2'b00; rw_wrn = 1'b1; en_rdn = 1'b0; tick(4);
        rd_seq(1'b1, dcv, drop_cs, "R4");
    endtask

    task automatic t_i80_read(input logic dcv, input bit drop_cs);
        mode_sel = 2'b01; rw_wrn = 1'b1; en_rdn = 1'b1; tick(4);
        rd_seq(1'b0, dcv, drop_cs, "R6");
    endtask

    task automatic ser_bit(input logic b);
        bus_in[7] = b; tick(3);
        bus_in[6] = 1'b1; tick(3);
        bus_in[6] = 1'b0; tick(3);
    endtask

    task automatic ser_byte(input logic [7:0] d, input logic dcv, input string req);
        for (int i = 7; i >= 1; i--) ser_bit(d[i]);
        bus_in[7] = d[0]; dc_sel = dcv; tick(3);
        bus_in[6] = 1'b1;
        expect_wr(d, dcv, req);
        bus_in[6] = 1'b0; tick(3);
    endtask

    task automatic ser_setup();
        mode_sel = 2'b10; rw_wrn = 1'b0; en_rdn = 1'b1; bus_in = '0; tick(4);
        cs1_n = 1'b0; cs2 = 1'b1; dc_sel = 1'b0; tick(4);
    endtask

    task automatic t_serial();
        int start;
        ser_setup();
        start = wr_cnt;
        ser_byte(8'hC3, 1'b1, "R7 C3");
        ser_byte(8'h01, 1'b0, "R7 01");
        tick(4);
        chk(wr_cnt - start == 2, "R7 count", wr_cnt - start, 2);
        deselect();
    endtask

    task automatic t_serial_resync();
        int start;
        ser_setup();
        ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b1);
        deselect();
        cs1_n = 1'b0; cs2 = 1'b1; tick(4);
        start = wr_cnt;
        ser_byte(8'h96, 1'b1, "R8 restart");
        tick(4);
        chk(wr_cnt - start == 1, "R8 count", wr_cnt - start, 1);
        deselect();
    endtask

    task automatic t_mode_off();
        int ws, rs;
        ws = wr_cnt; rs = rd_cnt;
        mode_sel = 2'b11; rw_wrn = 1'b0; en_rdn = 1'b0; tick(4);
        cs1_n = 1'b0; cs2 = 1'b1; bus_in = 8'h77; tick(4);
        en_rdn = 1'b1; tick(4); en_rdn = 1'b0; tick(4);
        rw_wrn = 1'b1; tick(4); rw_wrn = 1'b0; tick(2); rw_wrn = 1'b1; tick(4);
        chk(bus_oe == 1'b0, "R9 no drive", bus_oe, 0);
        en_rdn = 1'b1; tick(6);
        chk(bus_oe == 1'b0, "R9 no drive m68 read", bus_oe, 0);
        chk(wr_cnt == ws, "R9 no write", wr_cnt - ws, 0);
        chk(rd_cnt == rs, "R9 no read", rd_cnt - rs, 0);
        en_rdn = 1'b0; rw_wrn = 1'b0;
        deselect();
    endtask

    task automatic t_rst_filter();
        rst_pin_n = 1'b0; tick(500);
        rst_pin_n = 1'b1; tick(6);
        chk(init_cnt == 0, "R11 short pulse", init_cnt, 0);
        rst_pin_n = 1'b0; tick(2100);
        rst_pin_n = 1'b1; tick(6);
        chk(init_cnt == 1, "R11 long pulse", init_cnt, 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        t_reset();
        t_m68_write(8'h81, 1'b1, 1'b1);   // R12 MSB/LSB at bit 7 / bit 0
        t_m68_write(8'h3C, 1'b0, 1'b1);
        t_m68_write(8'hFF, 1'b1, 1'b0);   // R1 deselected
        t_i80_write(8'h5E, 1'b0, 1'b1);
        t_i80_write(8'hE7, 1'b1, 1'b1);
        t_i80_write(8'h12, 1'b1, 1'b0);   // R1 cs2 low
        t_m68_read(1'b1, 1'b0);
        t_m68_read(1'b0, 1'b1);           // R10 release via chip select
        t_i80_read(1'b0, 1'b0);
        t_i80_read(1'b1, 1'b1);
        t_serial();
        t_serial_resync();
        t_mode_off();
        t_rst_filter();
        done = 1;
        finish_run();
    end
endmodule